// File: doc/BRIEF.md
# Backlight PWM with Staged Commit

This block produces a single pulse-width-modulated pin for display backlight dimming. A prescaler divides the input clock into ticks. A period counter counts those ticks through one PWM cycle, and a duty compare holds the pin high for the first part of each cycle. Software drives the block through a simple register bus: a select, a write strobe, an address, 32-bit write data and combinational read data. Each access completes in one cycle, and all 32 bits are written at once.

The divider, period and high-width fields are written into staging registers, and writing them does not change the waveform. A commit strobe hands them over: software writes 1 and then 0 to the commit bit. The staged set then moves into the active registers at the next cycle boundary, so no cycle is ever cut short or stretched. While the output is disabled, the set moves over at once, so the first cycle after enable already uses it.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is low.
- R2: Bit 0 at address 0x00 is the enable. While it is 0, `pwm_out` is low and both counters are held at zero. In the first clock after it is set, a new cycle starts at count 0, so the pin is high in that clock whenever the active high width is nonzero.
- R3: The divider is the 10-bit field [25:16] at address 0x10. One prescaled tick lasts (divider + 1) clocks, for every divider value from 0 up to 0x3FF.
- R4: The period is the 12-bit field [11:0] at address 0x14. One PWM cycle lasts (period + 1) ticks.
- R5: The high width is the 13-bit field [28:16] at address 0x14. Each cycle starts with `pwm_out` high for (high width) ticks, followed by low for the rest of the cycle.
- R6: A high width of period + 1 or more keeps `pwm_out` high for the whole cycle. A high width of 0 keeps it low.
- R7: Writes to 0x10 and 0x14 change only the staged values. The waveform does not change until a commit.
- R8: A commit occurs only when bit 0 at address 0x08 is written as 1 while its stored value is 0. Writing 1 again while the stored value is already 1 commits nothing.
- R9: After a commit, the staged divider, period and high width become active together. While enabled, this happens at the end of the current PWM cycle. While disabled, it happens on the next clock.
- R10: Readback returns the stored fields in their bit positions, with all other bits reading 0. Address 0x04, and any other address not listed above, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| pwm_out | output | 1 | PWM output pin |

## Verification
The assertions rely on one assumption about the inputs: the active values change only through the staged transfer. That assumption is what lets the counter bounds and the full-high and zero-width properties hold in every cycle. They also rely on bus inputs being stable around each clock edge, with at most one access per cycle. The stimulus meets this by driving every access at a falling edge and holding it across exactly one rising edge. The stimulus also crosses each cycle boundary with a commit pending, and writes commit as 1 both from 0 and from 1.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int BUS_W = 32;

  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_COMMIT = 8'h08;
  localparam logic [7:0] OFS_CTL_DIV = 8'h10;
  localparam logic [7:0] OFS_CTL_SHAPE = 8'h14;

  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HIGH_LSB = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              en_o,
  output logic [DIV_W-1:0]  stg_div_o,
  output logic [PER_W-1:0]  stg_per_o,
  output logic [HIGH_W-1:0] stg_high_o,
  output logic              commit_o
);
  logic cbit_q;
  logic unused_wdata;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_en, wr_cm, wr_c0, wr_c1;
  assign wr_en = bus_sel && bus_wr && at(bus_addr, OFS_ENABLE);
  assign wr_cm = bus_sel && bus_wr && at(bus_addr, OFS_COMMIT);
  assign wr_c0 = bus_sel && bus_wr && at(bus_addr, OFS_CTL_DIV);
  assign wr_c1 = bus_sel && bus_wr && at(bus_addr, OFS_CTL_SHAPE);

  assign commit_o = wr_cm && bus_wdata[0] && !cbit_q;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= 1'b0;
      cbit_q <= 1'b0;
      stg_div_o <= '0;
      stg_per_o <= '0;
      stg_high_o <= '0;
    end else begin
      if (wr_en) en_o <= bus_wdata[0];
      if (wr_cm) cbit_q <= bus_wdata[0];
      if (wr_c0) stg_div_o <= bus_wdata[DIV_LSB +: DIV_W];
      if (wr_c1) begin
        stg_per_o <= bus_wdata[PER_LSB +: PER_W];
        stg_high_o <= bus_wdata[HIGH_LSB +: HIGH_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (at(bus_addr, OFS_ENABLE)) bus_rdata = BUS_W'(en_o);
      else if (at(bus_addr, OFS_COMMIT)) bus_rdata = BUS_W'(cbit_q);
      else if (at(bus_addr, OFS_CTL_DIV)) bus_rdata = BUS_W'(stg_div_o) << DIV_LSB;
      else if (at(bus_addr, OFS_CTL_SHAPE))
        bus_rdata = (BUS_W'(stg_high_o) << HIGH_LSB) | (BUS_W'(stg_per_o) << PER_LSB);
    end
  end
endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_cycle.sv
module bl_pwm_cycle #(
  parameter int PER_W = 12,
  localparam int HIGH_W = PER_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [PER_W-1:0]  last,
  input  logic [HIGH_W-1:0] high,
  output logic              wrap,
  output logic [PER_W-1:0]  cnt,
  output logic              pwm
);
  function automatic logic duty_on(input logic [PER_W-1:0] c, input logic [HIGH_W-1:0] h);
    return {1'b0, c} < h;
  endfunction

  assign wrap = tick && (cnt == last);
  assign pwm = run && duty_on(cnt, high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W = 10,
  parameter int PER_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  localparam int HIGH_W = PER_W + 1;

  logic              en;
  logic              commit_evt;
  logic [DIV_W-1:0]  stg_div, act_div, pre_cnt;
  logic [PER_W-1:0]  stg_per, act_per, per_cnt;
  logic [HIGH_W-1:0] stg_high, act_high;
  logic              pend_q, tick, wrap, load;

  bl_pwm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_o(en), .stg_div_o(stg_div), .stg_per_o(stg_per), .stg_high_o(stg_high),
    .commit_o(commit_evt)
  );

  bl_pwm_prescale #(.DIV_W(DIV_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(en), .limit(act_div), .tick(tick), .cnt(pre_cnt)
  );

  bl_pwm_cycle #(.PER_W(PER_W)) cyc_i (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick), .last(act_per),
    .high(act_high), .wrap(wrap), .cnt(per_cnt), .pwm(pwm_out)
  );

  // Hand-over point: cycle boundary when running, next clock when stopped
  assign load = (pend_q || commit_evt) && (wrap || !en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      act_per <= '0;
      act_high <= '0;
      pend_q <= 1'b0;
    end else if (load) begin
      act_div <= stg_div;
      act_per <= stg_per;
      act_high <= stg_high;
      pend_q <= 1'b0;
    end else if (commit_evt) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  localparam int HIGH_W = PER_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              wrap,
  input logic              load,
  input logic              commit_evt,
  input logic              pend_q,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic [DIV_W-1:0]  act_div,
  input logic [PER_W-1:0]  per_cnt,
  input logic [PER_W-1:0]  act_per,
  input logic [HIGH_W-1:0] act_high,
  input logic              pwm_out
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out); // R2
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (pre_cnt == '0 && per_cnt == '0)); // R2
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= act_div); // R3
  AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    per_cnt <= act_per); // R4
  AST_CYCLE_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_cnt == '0 && act_high != '0) |-> pwm_out); // R5
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_high > {1'b0, act_per}) |-> pwm_out); // R6
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high == '0) |-> !pwm_out); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_div) && $stable(act_per) && $stable(act_high))); // R7
  AST_COMMIT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !load) |=> pend_q); // R8
  AST_LOAD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && en) |-> wrap); // R9
endmodule

bind bl_pwm_top bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .load(load),
  .commit_evt(commit_evt), .pend_q(pend_q), .pre_cnt(pre_cnt), .act_div(act_div),
  .per_cnt(per_cnt), .act_per(act_per), .act_high(act_high), .pwm_out(pwm_out)
);

// File: tb/bl_pwm_top_tb_top.sv
module bl_pwm_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int tot = 0;
  int bad = 0;

  bl_pwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference: integer state advanced once per rising edge
  int m_en, m_cbit, m_pend, m_pre, m_cnt;
  int s_div, s_per, s_high, a_div, a_per, a_high;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cbit = 0; m_pend = 0; m_pre = 0; m_cnt = 0;
      s_div = 0; s_per = 0; s_high = 0; a_div = 0; a_per = 0; a_high = 0;
    end else begin
      bit w, ce, tk, wp, ld;
      w = bus_sel && bus_wr;
      ce = w && bus_addr == 8'h08 && bus_wdata[0] && m_cbit == 0;
      tk = m_en != 0 && m_pre == a_div;
      wp = tk && m_cnt == a_per;
      ld = (m_pend != 0 || ce) && (wp || m_en == 0);
      if (m_en == 0) begin m_pre = 0; m_cnt = 0; end
      else if (tk) begin m_pre = 0; m_cnt = wp ? 0 : m_cnt + 1; end
      else m_pre = m_pre + 1;
      if (ld) begin a_div = s_div; a_per = s_per; a_high = s_high; m_pend = 0; end
      else if (ce) m_pend = 1;
      if (w) begin
        case (bus_addr)
          8'h00: m_en = int'(bus_wdata[0]);
          8'h08: m_cbit = int'(bus_wdata[0]);
          8'h10: s_div = int'(bus_wdata[25:16]);
          8'h14: begin s_per = int'(bus_wdata[11:0]); s_high = int'(bus_wdata[28:16]); end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_o;
      exp_o = (m_en != 0 && m_cnt < a_high) ? 1 : 0;
      tot++;
      if (int'(pwm_out) != exp_o) begin
        bad++;
        $display("FAIL waveform R3 R4 R5 R7 R9 t=%0t actual=%0d expected=%0d", $time, pwm_out, exp_o);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp_v);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp_v, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == exp_v, tag, bus_rdata, exp_v);
    bus_sel = 1'b0;
  endtask

  task automatic commit();
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h1);
  endtask

  task automatic count_hi(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tot++; bad++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(pwm_out == 1'b0, "R1 pwm after reset", pwm_out, 0);
    rd_chk(8'h00, 32'h0, "R1 enable reset");
    rd_chk(8'h08, 32'h0, "R1 commit reset");
    rd_chk(8'h10, 32'h0, "R1 divider reset");
    rd_chk(8'h14, 32'h0, "R1 shape reset");

    // R10: readback of masked fields
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h03FF_0000, "R10 divider field");
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'h1FFF_0FFF, "R10 shape fields");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0, "R10 unmapped address");

    // R9: commit while disabled takes effect at once
    wr(8'h10, 32'h0001_0000);   // divider 1
    wr(8'h14, 32'h0003_0009);   // high 3, period 9
    commit();
    rd_chk(8'h08, 32'h1, "R8 commit bit stored");
    chk(pwm_out == 1'b0, "R2 disabled output low", pwm_out, 0);

    // R2: enabling starts a cycle high
    wr(8'h00, 32'h1);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R2 first clock of cycle", pwm_out, 1);
    count_hi(40, hi);
    chk(hi == 12, "R3 R4 R5 high clocks per two cycles", hi, 12);

    // R7: staged values do not act without commit
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0002_0004);
    count_hi(40, hi);
    chk(hi == 12, "R7 staged values ignored", hi, 12);

    // R8: writing 1 over a stored 1 is no commit
    wr(8'h08, 32'h1);
    count_hi(40, hi);
    chk(hi == 12, "R8 repeated one is no commit", hi, 12);

    // R8 R9: proper commit applies at the cycle boundary
    commit();
    repeat (25) @(negedge clk);
    count_hi(10, hi);
    chk(hi == 4, "R8 R9 new set after boundary", hi, 4);

    // R6: full and zero widths
    wr(8'h14, 32'h0005_0004);
    commit();
    repeat (10) @(negedge clk);
    count_hi(10, hi);
    chk(hi == 10, "R6 width equal to period plus one", hi, 10);
    wr(8'h14, 32'h1FFF_0004);
    commit();
    repeat (10) @(negedge clk);
    count_hi(10, hi);
    chk(hi == 10, "R6 maximum width", hi, 10);
    wr(8'h14, 32'h0000_0004);
    commit();
    repeat (10) @(negedge clk);
    count_hi(10, hi);
    chk(hi == 0, "R6 zero width", hi, 0);

    // R2: disable forces low
    wr(8'h14, 32'h0005_0004);
    commit();
    repeat (10) @(negedge clk);
    wr(8'h00, 32'h0);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R2 disable forces low", pwm_out, 0);
    count_hi(10, hi);
    chk(hi == 0, "R2 stays low while disabled", hi, 0);

    // R9: commit while disabled, then enable
    wr(8'h10, 32'h0002_0000);
    wr(8'h14, 32'h0002_0004);
    commit();
    wr(8'h00, 32'h1);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R9 disabled commit used at enable", pwm_out, 1);
    count_hi(30, hi);
    chk(hi == 12, "R3 R9 divider 2 duty", hi, 12);

    // R3: largest divider
    wr(8'h10, 32'h03FF_0000);
    wr(8'h14, 32'h0001_0001);
    commit();
    repeat (2100) @(negedge clk);
    count_hi(2048, hi);
    chk(hi == 1024, "R3 maximum divider", hi, 1024);

    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule